// File: doc/BRIEF.md
# Video Line Interrupt Controller

This block merges three video timing events into one active-high interrupt request. The three events are a vertical sync event, an event on line 21 and an event on line 284. The vertical sync event is taken from the rising edge of a sync input. The two line events come from a line-start strobe together with the current line number. Each event has its own capture enable. Each event also has its own pending bit, which software clears by writing ones. The interrupt output is high whenever any pending bit is set.

The design is built around one rule: an enable only controls whether a new event is captured. Once a bit is pending, removing its enable does not drop it. Only a write-one clear does. The pending vector can be read back so that software can see which event raised the request.

Top module: `vli_ctrl`

## Requirements
- R1: After synchronous reset, the pending vector is 0, the interrupt output is low and all three enables are 0, so an event arriving before any enable write sets nothing.
- R2: Bit 0 of the pending vector is set by a rising edge of `vsync_i`. Keeping `vsync_i` high on later cycles does not raise the event again.
- R3: A cycle with `line_strobe_i` high and `line_num_i` equal to 21 sets pending bit 1. With `line_num_i` equal to 284 it sets pending bit 2. Other line numbers, or those numbers without the strobe, set nothing.
- R4: A new event sets its pending bit only when its enable bit is 1. The enable, clear and pending vectors all use the same bit order: bit 0 vsync, bit 1 line 21, bit 2 line 284.
- R5: `irq_o` is high exactly when at least one pending bit is set. It can fall only after a clear write.
- R6: A cycle with `clr_wr_i` high clears every pending bit whose `clr_wdata_i` bit is 1. A 0 bit in `clr_wdata_i` leaves its pending bit unchanged.
- R7: Clearing an enable bit does not clear a pending bit that is already set. The bit stays set until it is cleared by a write.
- R8: If an enabled event and a clear of the same bit arrive in the same cycle, the bit ends set.
- R9: An enable write replaces all three enables. It applies to events from the following cycle on. An event in the same cycle as the write is captured against the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_i | input | 1 | Vertical sync level; a rising edge is the event |
| line_num_i | input | LINE_W | Current line number |
| line_strobe_i | input | 1 | One-cycle pulse at the start of each line |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 3 | New enable vector |
| clr_wr_i | input | 1 | Clear register write strobe |
| clr_wdata_i | input | 3 | Write-one-to-clear mask |
| irq_o | output | 1 | Active-high interrupt request |
| pending_o | output | 3 | Pending event vector |

## Verification
The hardest case to reach is a cycle where an event, a clear and possibly an enable write meet on the same bit. The outcome then depends on a precedence rule and on which enable value is in force. The stimulus drives each input field separately on every cycle. This lets a line-21 strobe be placed in the same cycle as a clear of bit 1, and in the same cycle as the enable write that turns that source on. The scoreboard predicts the result using the old enable value. A separate sequence holds vsync high across a clear, which shows that a level does not raise the event again.

// File: rtl/vli_pkg.sv
package vli_pkg;
    localparam int NUM_SRC = 3;

    typedef enum int unsigned {
        SRC_VSYNC = 0,
        SRC_LINE_A = 1,
        SRC_LINE_B = 2
    } src_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic     wr;
        src_vec_t data;
    } reg_wr_t;

    function automatic src_vec_t wr_mask(reg_wr_t w);
        return w.wr ? w.data : '0;
    endfunction
endpackage

// File: rtl/vli_evt_detect.sv
module vli_evt_detect
    import vli_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int LINE_A = 21,
    parameter int LINE_B = 284
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vsync_i,
    input  logic [LINE_W-1:0] line_num_i,
    input  logic              line_strobe_i,
    output src_vec_t          evt_o
);
    localparam int NUM_LINE_SRC = NUM_SRC - 1;

    logic vsync_q;

    always_ff @(posedge clk) begin
        if (rst) vsync_q <= 1'b0;
        else     vsync_q <= vsync_i;
    end

    assign evt_o[SRC_VSYNC] = vsync_i & ~vsync_q;

    for (genvar i = 0; i < NUM_LINE_SRC; i++) begin : g_line
        localparam logic [LINE_W-1:0] MATCH = LINE_W'(i == 0 ? LINE_A : LINE_B);
        assign evt_o[i+1] = line_strobe_i && (line_num_i == MATCH);
    end
endmodule

// File: rtl/vli_pend_bit.sv
module vli_pend_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/vli_ctrl.sv
module vli_ctrl
    import vli_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int LINE_A = 21,
    parameter int LINE_B = 284
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vsync_i,
    input  logic [LINE_W-1:0] line_num_i,
    input  logic              line_strobe_i,
    input  logic              en_wr_i,
    input  logic [2:0]        en_wdata_i,
    input  logic              clr_wr_i,
    input  logic [2:0]        clr_wdata_i,
    output logic              irq_o,
    output logic [2:0]        pending_o
);
    src_vec_t evt_w;
    src_vec_t en_q;
    src_vec_t clr_w;
    src_vec_t pend_w;
    reg_wr_t  clr_req;

    vli_evt_detect #(
        .LINE_W(LINE_W),
        .LINE_A(LINE_A),
        .LINE_B(LINE_B)
    ) u_det (
        .clk          (clk),
        .rst          (rst),
        .vsync_i      (vsync_i),
        .line_num_i   (line_num_i),
        .line_strobe_i(line_strobe_i),
        .evt_o        (evt_w)
    );

    always_ff @(posedge clk) begin
        if (rst)          en_q <= '0;
        else if (en_wr_i) en_q <= en_wdata_i;
    end

    always_comb begin
        clr_req.wr   = clr_wr_i;
        clr_req.data = clr_wdata_i;
        clr_w        = wr_mask(clr_req);
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
        vli_pend_bit u_bit (
            .clk  (clk),
            .rst  (rst),
            .set_i(evt_w[i] & en_q[i]),
            .clr_i(clr_w[i]),
            .q_o  (pend_w[i])
        );
    end

    assign pending_o = pend_w;
    assign irq_o     = |pend_w;
endmodule

// File: rtl/vli_ctrl_chk.sv
module vli_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       clr_wr_i,
    input logic [2:0] clr_wdata_i,
    input logic       irq_o,
    input logic [2:0] pending_o,
    input logic [2:0] evt_w,
    input logic [2:0] en_q
);
    // R4: a bit that was clear with its enable off cannot become set
    p_disabled_no_set_r4: assert property (@(posedge clk) disable iff (rst)
        (pending_o & ~$past(pending_o) & ~$past(en_q)) == 3'b000);

    // R6: a write-one clear without a competing event empties those bits
    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_wr_i && ((clr_wdata_i & ~(evt_w & en_q)) != 3'b000)) |=>
        ((pending_o & $past(clr_wdata_i & ~(evt_w & en_q))) == 3'b000));

    // R7: a set bit only drops when a clear write names it
    p_hold_until_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (($past(pending_o) & ~($past(clr_wr_i) ? $past(clr_wdata_i) : 3'b000))
         & ~pending_o) == 3'b000);

    // R8: an enabled event wins over a clear of the same bit
    p_event_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_wr_i && ((evt_w & en_q & clr_wdata_i) != 3'b000)) |=>
        ((pending_o & $past(evt_w & en_q & clr_wdata_i)) == $past(evt_w & en_q & clr_wdata_i)));

    // R5: the request falls only after a clear write
    p_irq_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> $past(clr_wr_i));
endmodule

bind vli_ctrl vli_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_wr_i   (clr_wr_i),
    .clr_wdata_i(clr_wdata_i),
    .irq_o      (irq_o),
    .pending_o  (pending_o),
    .evt_w      (evt_w),
    .en_q       (en_q)
);

// File: tb/sim_vli_ctrl.sv
`timescale 1ns/1ps
module sim_vli_ctrl;
    localparam int LINE_W = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              vsync_i = 1'b0;
    logic [LINE_W-1:0] line_num_i = '0;
    logic              line_strobe_i = 1'b0;
    logic              en_wr_i = 1'b0;
    logic [2:0]        en_wdata_i = '0;
    logic              clr_wr_i = 1'b0;
    logic [2:0]        clr_wdata_i = '0;
    logic              irq_o;
    logic [2:0]        pending_o;

    always #2.5 clk = ~clk;

    vli_ctrl #(.LINE_W(LINE_W)) u0 (
        .clk(clk), .rst(rst), .vsync_i(vsync_i), .line_num_i(line_num_i),
        .line_strobe_i(line_strobe_i), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
        .clr_wr_i(clr_wr_i), .clr_wdata_i(clr_wdata_i),
        .irq_o(irq_o), .pending_o(pending_o)
    );

    typedef struct {
        logic [2:0] pend;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    logic [2:0] m_pend = '0;
    logic [2:0] m_en = '0;
    logic       m_vs = 1'b0;
    bit         done = 1'b0;

    // monitor: compares one expected item per clock, after the edge settles
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (pending_o !== e.pend) begin
                errors++;
                $display("FAIL %s pending actual %b expected %b", e.tag, pending_o, e.pend);
            end
            checks++;
            if (irq_o !== (|e.pend)) begin
                errors++;
                $display("FAIL R5 (%s) irq actual %b expected %b", e.tag, irq_o, |e.pend);
            end
        end
    end

    // driver: applies one cycle of stimulus and pushes the predicted result
    task automatic drive(input logic vs, input int line, input logic stb,
                         input logic enw, input logic [2:0] enwd,
                         input logic clrw, input logic [2:0] clrd, input string tag);
        logic [2:0] evt;
        exp_t e;
        @(negedge clk);
        vsync_i = vs; line_num_i = LINE_W'(line); line_strobe_i = stb;
        en_wr_i = enw; en_wdata_i = enwd; clr_wr_i = clrw; clr_wdata_i = clrd;
        evt[0] = vs & ~m_vs;
        evt[1] = stb && (line == 21);
        evt[2] = stb && (line == 284);
        m_pend = (m_pend & ~(clrw ? clrd : 3'b000)) | (evt & m_en);
        if (enw) m_en = enwd;
        m_vs = vs;
        e.pend = m_pend;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input logic vs, input string tag);
        drive(vs, 0, 1'b0, 1'b0, 3'b000, 1'b0, 3'b000, tag);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (pending_o !== 3'b000 || irq_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual %b/%b expected 000/0", pending_o, irq_o);
        end
        // R1: enables reset to zero, events are dropped
        drive(1'b1, 0, 1'b0, 1'b0, 3'b000, 1'b0, 3'b000, "R1 vsync before enable");
        drive(1'b0, 21, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, "R1 line21 before enable");
        drive(1'b0, 0, 1'b0, 1'b1, 3'b111, 1'b0, 3'b000, "R4 enable all");
        // R2: rising edge only
        idle(1'b1, "R2 vsync rise");
        drive(1'b1, 0, 1'b0, 1'b0, 3'b000, 1'b1, 3'b001, "R2 clear while vsync held");
        idle(1'b1, "R2 vsync level no refire");
        idle(1'b0, "R2 vsync low");
        // R3: line matching
        drive(1'b0, 20, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, "R3 line 20 ignored");
        drive(1'b0, 21, 1'b0, 1'b0, 3'b000, 1'b0, 3'b000, "R3 line 21 no strobe");
        drive(1'b0, 21, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, "R3 line 21 strobe");
        drive(1'b0, 284, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, "R3 line 284 strobe");
        drive(1'b0, 285, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, "R3 line 285 ignored");
        // R6: zero mask, partial mask
        drive(1'b0, 0, 1'b0, 1'b0, 3'b000, 1'b1, 3'b000, "R6 zero mask");
        drive(1'b0, 0, 1'b0, 1'b0, 3'b000, 1'b1, 3'b010, "R6 clear bit1 only");
        // R7: disabling keeps pending
        drive(1'b0, 0, 1'b0, 1'b1, 3'b000, 1'b0, 3'b000, "R7 disable all");
        idle(1'b0, "R7 pending held");
        drive(1'b0, 0, 1'b0, 1'b0, 3'b000, 1'b1, 3'b111, "R7 clear all");
        // R4: per-source enable
        drive(1'b0, 0, 1'b0, 1'b1, 3'b010, 1'b0, 3'b000, "R4 enable line21 only");
        idle(1'b1, "R4 vsync disabled");
        drive(1'b0, 284, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, "R4 line284 disabled");
        drive(1'b0, 21, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, "R4 line21 enabled");
        // R8: event beats clear
        drive(1'b0, 21, 1'b1, 1'b0, 3'b000, 1'b1, 3'b010, "R8 event with clear");
        drive(1'b0, 0, 1'b0, 1'b1, 3'b000, 1'b1, 3'b111, "R8 clear and disable");
        // R9: enable write timing
        drive(1'b0, 21, 1'b1, 1'b1, 3'b111, 1'b0, 3'b000, "R9 event in enable write cycle");
        drive(1'b0, 21, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, "R9 event after enable write");
        drive(1'b1, 284, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, "R5 two sources same cycle");
        drive(1'b0, 0, 1'b0, 1'b0, 3'b000, 1'b1, 3'b111, "R5 clear all drops irq");
        idle(1'b0, "R5 idle");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule